// File: doc/BRIEF.md
# Write-Back Compressed Size Change Classifier

This block sits beside a compressed main memory and acts on each block that is written back with a new compressed byte count. It maps the byte count to one of a small set of block size classes and compares that class with the class the block held before. It then grades the change as one of six events: overflow or underflow at block level, sub-page level or page level.

Block-level and sub-page-level events are handed to an external data mover through a valid/ready request. The request carries the page, sub-page and block numbers and a two-bit kind code. Page-level events raise a trap that is held until software acknowledges it. While the mover owns a page, any access to that page is stalled. The new class is released for the size table only after the mover reports completion or the trap is acknowledged. A write-back that leaves the class unchanged causes no action at all.

The class capacities are evenly spaced from zero up to the full block size, and each is rounded up to a whole byte. With the default 64-byte block and four classes, the capacities are 0, 22, 43 and 64 bytes.

Top module: `wbsize_classifier`

## Requirements
- R1: The new class is the smallest class whose capacity (0, 22, 43, 64 bytes by default) holds the new byte count. A count above the block size maps to the top class (3). This class is the one written out on `cls_wr_cls`.
- R2: When the new class equals the old class, no move request, no trap and no class write follow, and `upd_ready` stays high.
- R3: Growth (new capacity minus old capacity) that is no larger than the sub-page slack issues a move request with `mv_kind` = 2'b01. This includes growth exactly equal to the slack.
- R4: Growth that is larger than the sub-page slack but no larger than the page slack issues a move request with `mv_kind` = 2'b11.
- R5: Growth that is larger than the page slack raises `trap_valid` with `trap_grow` = 1 and issues no move request. At most one of `mv_valid`, `trap_valid` and `cls_wr_valid` is high at any time.
- R6: For a class drop, let freed space be the old capacity minus the new capacity. If page slack plus freed space exceeds `cfg_page_thr`, a trap is raised with `trap_grow` = 0. Otherwise, if sub-page slack plus freed space exceeds `cfg_sub_thr`, a move with `mv_kind` = 2'b10 is issued. Otherwise a move with `mv_kind` = 2'b00 is issued.
- R7: A move request appears in the cycle after the update is accepted. It holds `mv_valid` and its page, sub-page, block and kind fields steady until `mv_ready` is sampled high.
- R8: `stall` is high when `acc_valid` is high and `acc_page` equals the moving page, in any cycle from the request-acceptance cycle through the cycle in which `mv_done` is sampled, inclusive.
- R9: `trap_valid` and its fields stay steady until `trap_ack` is sampled high.
- R10: `cls_wr_valid` pulses for exactly one cycle, in the cycle after `mv_done` (during a move) or `trap_ack` (during a trap) is sampled. It carries the update's page, sub-page and block numbers.
- R11: `upd_ready` is high only while no change is in progress. An update offered while it is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Write-back size update offered |
| upd_ready | output | 1 | Block idle, update accepted |
| upd_page | input | PAGE_W | Page number of the written block |
| upd_sub | input | SUB_W | Sub-page index within the page |
| upd_blk | input | BLK_W | Block index within the sub-page |
| upd_old_cls | input | CLS_W | Stored size class of the block |
| upd_bytes | input | CNT_W | New compressed byte count |
| upd_sub_slack | input | SLACK_W | Free bytes left in the sub-page |
| upd_page_slack | input | SLACK_W | Free bytes left in the page |
| cfg_sub_thr | input | SLACK_W | Sub-page underflow threshold |
| cfg_page_thr | input | SLACK_W | Page underflow threshold |
| mv_valid | output | 1 | Move request valid |
| mv_ready | input | 1 | Mover accepts request |
| mv_page | output | PAGE_W | Page to rearrange |
| mv_sub | output | SUB_W | Sub-page of the changed block |
| mv_blk | output | BLK_W | Changed block |
| mv_kind | output | 2 | {sub-page level, growth} |
| mv_done | input | 1 | Mover completion pulse |
| trap_valid | output | 1 | Page relocation trap |
| trap_ack | input | 1 | Trap handled |
| trap_page | output | PAGE_W | Page to remap |
| trap_grow | output | 1 | 1 overflow, 0 underflow |
| cls_wr_valid | output | 1 | Size class table write |
| cls_wr_page | output | PAGE_W | Page of the table entry |
| cls_wr_sub | output | SUB_W | Sub-page of the table entry |
| cls_wr_blk | output | BLK_W | Block of the table entry |
| cls_wr_cls | output | CLS_W | New class value |
| acc_valid | input | 1 | Processor access present |
| acc_page | input | PAGE_W | Page of the access |
| stall | output | 1 | Access must wait |

## Verification
Two situations can fall in the same cycle, and the bench drives both on purpose.

- The mover can take the request in the very cycle that an access to the same page arrives. The stall must already be high in that cycle, before the busy state is registered.
- The completion pulse can coincide with an access to the moving page. That access must still be stalled, and the class write must follow one cycle later.

Both are driven in directed steps and reappear many times in a randomized phase with a small page range. A behavioural model in the bench computes, for every cycle, the expected handshake, trap, write-back and stall values and compares them with the outputs.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_BLK_OVF,
      EV_SUB_OVF,
      EV_PG_OVF,
      EV_BLK_UNF,
      EV_SUB_UNF,
      EV_PG_UNF
   } wsc_event_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_MOVE,
      ST_TRAP,
      ST_WRITE
   } wsc_state_e;

   // capacity in bytes of class c: evenly spaced, rounded up
   function automatic int unsigned wsc_cap(input int unsigned c,
                                           input int unsigned blk_bytes,
                                           input int unsigned n_class);
      return (c * blk_bytes + n_class - 2) / (n_class - 1);
   endfunction

endpackage

// File: rtl/wsc_class_map.sv
module wsc_class_map
   import wsc_pkg::*;
#(
   parameter int BLK_BYTES  = 64,
   parameter int N_CLASS    = 4,
   parameter int CNT_W      = 7,
   parameter int CLS_W      = 2,
   parameter bit MAP_THERMO = 1'b1
) (
   input  logic [CNT_W-1:0] bytes,
   output logic [CLS_W-1:0] cls
);

   if (MAP_THERMO) begin : g_thermo
      logic [N_CLASS-2:0] above;
      for (genvar c = 1; c < N_CLASS; c++) begin : g_cmp
         assign above[c-1] = bytes > CNT_W'(wsc_cap(c - 1, BLK_BYTES, N_CLASS));
      end
      always_comb begin
         cls = '0;
         for (int i = 0; i < N_CLASS - 1; i++) begin
            cls = cls + CLS_W'(above[i]);
         end
      end
   end else begin : g_scan
      always_comb begin
         cls = CLS_W'(N_CLASS - 1);
         for (int c = N_CLASS - 2; c >= 0; c--) begin
            if (bytes <= CNT_W'(wsc_cap(c, BLK_BYTES, N_CLASS))) begin
               cls = CLS_W'(c);
            end
         end
      end
   end

endmodule

// File: rtl/wsc_grader.sv
module wsc_grader
   import wsc_pkg::*;
#(
   parameter int BLK_BYTES = 64,
   parameter int N_CLASS   = 4,
   parameter int CLS_W     = 2,
   parameter int SLACK_W   = 13
) (
   input  logic [CLS_W-1:0]   old_cls,
   input  logic [CLS_W-1:0]   new_cls,
   input  logic [SLACK_W-1:0] sub_slack,
   input  logic [SLACK_W-1:0] page_slack,
   input  logic [SLACK_W-1:0] sub_thr,
   input  logic [SLACK_W-1:0] page_thr,
   output wsc_event_e         evt
);

   localparam int SW      = SLACK_W + 1;
   localparam int TAB_LEN = 1 << CLS_W;

   logic [SW-1:0] cap_tab [TAB_LEN];

   for (genvar c = 0; c < TAB_LEN; c++) begin : g_cap
      if (c < N_CLASS) begin : g_real
         assign cap_tab[c] = SW'(wsc_cap(c, BLK_BYTES, N_CLASS));
      end else begin : g_sat
         assign cap_tab[c] = SW'(BLK_BYTES);
      end
   end

   logic [SW-1:0] old_cap, new_cap, delta, sub_after, page_after;

   always_comb begin
      old_cap    = cap_tab[old_cls];
      new_cap    = cap_tab[new_cls];
      delta      = (new_cap > old_cap) ? (new_cap - old_cap) : (old_cap - new_cap);
      sub_after  = {1'b0, sub_slack} + delta;
      page_after = {1'b0, page_slack} + delta;
      evt        = EV_NONE;
      if (new_cls > old_cls) begin
         if (delta <= {1'b0, sub_slack}) begin
            evt = EV_BLK_OVF;
         end else if (delta <= {1'b0, page_slack}) begin
            evt = EV_SUB_OVF;
         end else begin
            evt = EV_PG_OVF;
         end
      end else if (new_cls < old_cls) begin
         if (page_after > {1'b0, page_thr}) begin
            evt = EV_PG_UNF;
         end else if (sub_after > {1'b0, sub_thr}) begin
            evt = EV_SUB_UNF;
         end else begin
            evt = EV_BLK_UNF;
         end
      end
   end

endmodule

// File: rtl/wsc_busy_guard.sv
module wsc_busy_guard #(
   parameter int PAGE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant,
   input  logic              done,
   input  logic [PAGE_W-1:0] req_page,
   input  logic              acc_valid,
   input  logic [PAGE_W-1:0] acc_page,
   output logic              stall
);

   logic              busy_q;
   logic [PAGE_W-1:0] busy_page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         busy_page_q <= '0;
      end else if (grant) begin
         busy_q      <= 1'b1;
         busy_page_q <= req_page;
      end else if (done && busy_q) begin
         busy_q      <= 1'b0;
      end
   end

   always_comb begin
      stall = acc_valid &&
              ((busy_q && (acc_page == busy_page_q)) ||
               (grant  && (acc_page == req_page)));
   end

endmodule

// File: rtl/wbsize_classifier.sv
module wbsize_classifier
   import wsc_pkg::*;
#(
   parameter int  PAGE_W        = 20,
   parameter int  SUBS_PER_PAGE = 4,
   parameter int  BLKS_PER_SUB  = 16,
   parameter int  BLK_BYTES     = 64,
   parameter int  N_CLASS       = 4,
   parameter bit  MAP_THERMO    = 1'b1,
   localparam int SUB_W   = $clog2(SUBS_PER_PAGE),
   localparam int BLK_W   = $clog2(BLKS_PER_SUB),
   localparam int CLS_W   = $clog2(N_CLASS),
   localparam int CNT_W   = $clog2(BLK_BYTES + 1),
   localparam int SLACK_W = $clog2(BLK_BYTES * SUBS_PER_PAGE * BLKS_PER_SUB + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_valid,
   output logic               upd_ready,
   input  logic [PAGE_W-1:0]  upd_page,
   input  logic [SUB_W-1:0]   upd_sub,
   input  logic [BLK_W-1:0]   upd_blk,
   input  logic [CLS_W-1:0]   upd_old_cls,
   input  logic [CNT_W-1:0]   upd_bytes,
   input  logic [SLACK_W-1:0] upd_sub_slack,
   input  logic [SLACK_W-1:0] upd_page_slack,
   input  logic [SLACK_W-1:0] cfg_sub_thr,
   input  logic [SLACK_W-1:0] cfg_page_thr,
   output logic               mv_valid,
   input  logic               mv_ready,
   output logic [PAGE_W-1:0]  mv_page,
   output logic [SUB_W-1:0]   mv_sub,
   output logic [BLK_W-1:0]   mv_blk,
   output logic [1:0]         mv_kind,
   input  logic               mv_done,
   output logic               trap_valid,
   input  logic               trap_ack,
   output logic [PAGE_W-1:0]  trap_page,
   output logic               trap_grow,
   output logic               cls_wr_valid,
   output logic [PAGE_W-1:0]  cls_wr_page,
   output logic [SUB_W-1:0]   cls_wr_sub,
   output logic [BLK_W-1:0]   cls_wr_blk,
   output logic [CLS_W-1:0]   cls_wr_cls,
   input  logic               acc_valid,
   input  logic [PAGE_W-1:0]  acc_page,
   output logic               stall
);

   // elaboration-time parameter checks
   if (N_CLASS < 2) begin : g_bad_class
      $error("N_CLASS must be at least 2");
   end
   if (SUBS_PER_PAGE < 2 || BLKS_PER_SUB < 2) begin : g_bad_geom
      $error("need at least two sub-pages and two blocks per sub-page");
   end
   if (BLK_BYTES < N_CLASS - 1) begin : g_bad_blk
      $error("BLK_BYTES too small for the class count");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("PAGE_W must be positive");
   end

   logic [CLS_W-1:0] new_cls;
   wsc_event_e       evt;

   wsc_class_map #(
      .BLK_BYTES (BLK_BYTES),
      .N_CLASS   (N_CLASS),
      .CNT_W     (CNT_W),
      .CLS_W     (CLS_W),
      .MAP_THERMO(MAP_THERMO)
   ) u_map (
      .bytes(upd_bytes),
      .cls  (new_cls)
   );

   wsc_grader #(
      .BLK_BYTES(BLK_BYTES),
      .N_CLASS  (N_CLASS),
      .CLS_W    (CLS_W),
      .SLACK_W  (SLACK_W)
   ) u_grade (
      .old_cls   (upd_old_cls),
      .new_cls   (new_cls),
      .sub_slack (upd_sub_slack),
      .page_slack(upd_page_slack),
      .sub_thr   (cfg_sub_thr),
      .page_thr  (cfg_page_thr),
      .evt       (evt)
   );

   wsc_state_e        state_q;
   logic [PAGE_W-1:0] page_q;
   logic [SUB_W-1:0]  sub_q;
   logic [BLK_W-1:0]  blk_q;
   logic [CLS_W-1:0]  cls_q;
   logic [1:0]        kind_q;
   logic              grow_q;
   logic              take;

   assign upd_ready = (state_q == ST_IDLE);
   assign take      = upd_valid && upd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         page_q  <= '0;
         sub_q   <= '0;
         blk_q   <= '0;
         cls_q   <= '0;
         kind_q  <= 2'b00;
         grow_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (take) begin
                  page_q <= upd_page;
                  sub_q  <= upd_sub;
                  blk_q  <= upd_blk;
                  cls_q  <= new_cls;
                  unique case (evt)
                     EV_NONE:    state_q <= ST_IDLE;
                     EV_BLK_OVF: begin kind_q <= 2'b01; state_q <= ST_REQ; end
                     EV_SUB_OVF: begin kind_q <= 2'b11; state_q <= ST_REQ; end
                     EV_BLK_UNF: begin kind_q <= 2'b00; state_q <= ST_REQ; end
                     EV_SUB_UNF: begin kind_q <= 2'b10; state_q <= ST_REQ; end
                     EV_PG_OVF:  begin grow_q <= 1'b1;  state_q <= ST_TRAP; end
                     EV_PG_UNF:  begin grow_q <= 1'b0;  state_q <= ST_TRAP; end
                     default:    state_q <= ST_IDLE;
                  endcase
               end
            end
            ST_REQ:   if (mv_ready) state_q <= ST_MOVE;
            ST_MOVE:  if (mv_done)  state_q <= ST_WRITE;
            ST_TRAP:  if (trap_ack) state_q <= ST_WRITE;
            ST_WRITE: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mv_valid     = (state_q == ST_REQ);
   assign mv_page      = page_q;
   assign mv_sub       = sub_q;
   assign mv_blk       = blk_q;
   assign mv_kind      = kind_q;
   assign trap_valid   = (state_q == ST_TRAP);
   assign trap_page    = page_q;
   assign trap_grow    = grow_q;
   assign cls_wr_valid = (state_q == ST_WRITE);
   assign cls_wr_page  = page_q;
   assign cls_wr_sub   = sub_q;
   assign cls_wr_blk   = blk_q;
   assign cls_wr_cls   = cls_q;

   wsc_busy_guard #(
      .PAGE_W(PAGE_W)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (mv_valid && mv_ready),
      .done     (mv_done),
      .req_page (page_q),
      .acc_valid(acc_valid),
      .acc_page (acc_page),
      .stall    (stall)
   );

endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
   parameter int PAGE_W = 20,
   parameter int SUB_W  = 2,
   parameter int BLK_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_ready,
   input logic              mv_valid,
   input logic              mv_ready,
   input logic [PAGE_W-1:0] mv_page,
   input logic [SUB_W-1:0]  mv_sub,
   input logic [BLK_W-1:0]  mv_blk,
   input logic [1:0]        mv_kind,
   input logic              mv_done,
   input logic              trap_valid,
   input logic              trap_ack,
   input logic [PAGE_W-1:0] trap_page,
   input logic              trap_grow,
   input logic              cls_wr_valid,
   input logic              acc_valid,
   input logic              stall
);

   AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid && !mv_ready |=> mv_valid && $stable(mv_page) && $stable(mv_sub) && $stable(mv_blk) && $stable(mv_kind)); // R7

   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid && !trap_ack |=> trap_valid && $stable(trap_page) && $stable(trap_grow)); // R9

   AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cls_wr_valid |-> $past(mv_done || trap_ack)); // R10

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cls_wr_valid |=> !cls_wr_valid); // R10

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mv_valid, trap_valid, cls_wr_valid})); // R5

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid || trap_valid || cls_wr_valid) |-> !upd_ready); // R11

   AST_STALL_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> acc_valid); // R8

   AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_ready |-> !stall); // R8

endmodule

bind wbsize_classifier wsc_checker #(
   .PAGE_W(PAGE_W),
   .SUB_W (SUB_W),
   .BLK_W (BLK_W)
) u_wsc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd_ready   (upd_ready),
   .mv_valid    (mv_valid),
   .mv_ready    (mv_ready),
   .mv_page     (mv_page),
   .mv_sub      (mv_sub),
   .mv_blk      (mv_blk),
   .mv_kind     (mv_kind),
   .mv_done     (mv_done),
   .trap_valid  (trap_valid),
   .trap_ack    (trap_ack),
   .trap_page   (trap_page),
   .trap_grow   (trap_grow),
   .cls_wr_valid(cls_wr_valid),
   .acc_valid   (acc_valid),
   .stall       (stall)
);

// File: tb/wbsize_classifier_bench.sv
`timescale 1ns/1ps
module wbsize_classifier_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        upd_valid = 0, upd_ready;
   logic [19:0] upd_page = 0;
   logic [1:0]  upd_sub = 0;
   logic [3:0]  upd_blk = 0;
   logic [1:0]  upd_old_cls = 0;
   logic [6:0]  upd_bytes = 0;
   logic [12:0] upd_sub_slack = 0, upd_page_slack = 0;
   logic [12:0] cfg_sub_thr = 13'd30, cfg_page_thr = 13'd100;
   logic        mv_valid, mv_ready = 0, mv_done = 0;
   logic [19:0] mv_page;
   logic [1:0]  mv_sub, mv_kind;
   logic [3:0]  mv_blk;
   logic        trap_valid, trap_ack = 0, trap_grow;
   logic [19:0] trap_page;
   logic        cls_wr_valid;
   logic [19:0] cls_wr_page;
   logic [1:0]  cls_wr_sub, cls_wr_cls;
   logic [3:0]  cls_wr_blk;
   logic        acc_valid = 0;
   logic [19:0] acc_page = 0;
   logic        stall;

   wbsize_classifier u_wbsize_classifier (.*);

   int nchecks = 0;
   int nerr = 0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      nchecks++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   function automatic int ref_class(input int b);
      if (b == 0) return 0;      // R1 capacities 0,22,43,64
      if (b <= 22) return 1;
      if (b <= 43) return 2;
      return 3;
   endfunction

   function automatic int ref_cap(input int c);
      case (c)
         0: return 0;
         1: return 22;
         2: return 43;
         default: return 64;
      endcase
   endfunction

   int    ph = 0;            // 0 idle,1 request,2 moving,3 trap,4 write
   int    m_page = 0, m_sub = 0, m_blk = 0, m_cls = 0, m_kind = 0, m_grow = 0;
   string m_tag = "R2";

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0;
      end else begin
         case (ph)
            0: if (upd_valid) begin
               int nc, oc, d;
               nc = ref_class(upd_bytes);
               oc = upd_old_cls;
               m_page = upd_page; m_sub = upd_sub; m_blk = upd_blk; m_cls = nc;
               if (nc == oc) begin
                  m_tag = "R2";
               end else if (nc > oc) begin
                  d = ref_cap(nc) - ref_cap(oc);
                  if (d <= int'(upd_sub_slack)) begin ph = 1; m_kind = 1; m_tag = "R3"; end
                  else if (d <= int'(upd_page_slack)) begin ph = 1; m_kind = 3; m_tag = "R4"; end
                  else begin ph = 3; m_grow = 1; m_tag = "R5"; end
               end else begin
                  d = ref_cap(oc) - ref_cap(nc);
                  m_tag = "R6";
                  if (int'(upd_page_slack) + d > int'(cfg_page_thr)) begin ph = 3; m_grow = 0; end
                  else if (int'(upd_sub_slack) + d > int'(cfg_sub_thr)) begin ph = 1; m_kind = 2; end
                  else begin ph = 1; m_kind = 0; end
               end
            end
            1: if (mv_ready) ph = 2;
            2: if (mv_done) ph = 4;
            3: if (trap_ack) ph = 4;
            default: ph = 0;
         endcase
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      #1;
      chk("R11", "upd_ready", upd_ready, ph == 0);
      chk(ph == 1 ? "R7" : m_tag, "mv_valid", mv_valid, ph == 1);
      if (ph == 1 && mv_valid) begin
         chk(m_tag, "mv_kind", mv_kind, m_kind);
         chk("R7", "mv_page", mv_page, m_page);
         chk("R7", "mv_sub", mv_sub, m_sub);
         chk("R7", "mv_blk", mv_blk, m_blk);
      end
      chk(ph == 3 ? "R9" : m_tag, "trap_valid", trap_valid, ph == 3);
      if (ph == 3 && trap_valid) begin
         chk(m_tag, "trap_grow", trap_grow, m_grow);
         chk("R9", "trap_page", trap_page, m_page);
      end
      chk("R10", "cls_wr_valid", cls_wr_valid, ph == 4);
      if (ph == 4 && cls_wr_valid) begin
         chk("R1", "cls_wr_cls", cls_wr_cls, m_cls);
         chk("R10", "cls_wr_page", cls_wr_page, m_page);
         chk("R10", "cls_wr_sub", cls_wr_sub, m_sub);
         chk("R10", "cls_wr_blk", cls_wr_blk, m_blk);
      end
      chk("R8", "stall", stall,
          acc_valid && (int'(acc_page) == m_page) && (ph == 2 || (ph == 1 && mv_ready)));
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic upd(input int pg, input int sb, input int bk, input int oc,
                      input int by, input int ss, input int ps);
      @(negedge clk);
      upd_valid = 1; upd_page = 20'(pg); upd_sub = 2'(sb); upd_blk = 4'(bk);
      upd_old_cls = 2'(oc); upd_bytes = 7'(by);
      upd_sub_slack = 13'(ss); upd_page_slack = 13'(ps);
      @(negedge clk);
      upd_valid = 0;
   endtask

   task automatic finish_move(input int wait_rdy, input int wait_done);
      cyc(wait_rdy);
      mv_ready = 1; cyc(1); mv_ready = 0;
      cyc(wait_done);
      mv_done = 1; cyc(1); mv_done = 0;
      cyc(2);
   endtask

   initial begin
      cyc(4);
      rst_n = 1;
      cyc(2);

      // R2: class unchanged (40 bytes stays class 2)
      upd(1, 0, 0, 2, 40, 10, 10);
      cyc(3);

      // R3/R7/R8/R1: growth 1->2 of 21 bytes within sub slack 30; held 3 cycles,
      // access to the same page in the acceptance cycle and in the done cycle
      upd(5, 1, 3, 1, 40, 30, 60);
      cyc(3);
      acc_valid = 1; acc_page = 5;
      mv_ready = 1; cyc(1); mv_ready = 0;
      cyc(2);
      // R11: update offered while moving is ignored
      upd_valid = 1; upd_page = 9; upd_old_cls = 0; upd_bytes = 60;
      cyc(1); upd_valid = 0;
      mv_done = 1; cyc(1); mv_done = 0; acc_valid = 0;
      cyc(2);

      // R3 boundary: growth equals sub slack (1->2, 21 bytes)
      upd(6, 2, 1, 1, 43, 21, 21);
      finish_move(0, 1);

      // R4: growth 22 exceeds sub slack 10, fits page slack 50
      upd(7, 3, 15, 0, 22, 10, 50);
      acc_valid = 1; acc_page = 8;     // other page: no stall
      finish_move(1, 2);
      acc_valid = 0;

      // R5/R9/R1: 100 bytes clamps to class 3, growth 64 over page slack 40
      upd(8, 0, 2, 0, 100, 5, 40);
      cyc(4);
      trap_ack = 1; cyc(1); trap_ack = 0;
      cyc(2);

      // R6: page underflow, 50+64 > 100
      upd(9, 1, 4, 3, 0, 5, 50);
      cyc(2); trap_ack = 1; cyc(1); trap_ack = 0; cyc(2);

      // R6: sub-page underflow, 10+21 > 30, 10+21 <= 100
      upd(10, 2, 5, 2, 10, 10, 10);
      finish_move(0, 0);

      // R6: block underflow, 5+21 <= 30
      upd(11, 3, 6, 2, 22, 5, 5);
      finish_move(2, 0);

      // R1: boundaries 22->1, 23->2, 43->2, 44->3, 0->0
      upd(12, 0, 7, 0, 23, 100, 100); finish_move(0, 0);
      upd(12, 0, 8, 3, 22, 0, 0);     finish_move(0, 0);
      upd(12, 0, 9, 2, 44, 30, 30);   finish_move(0, 0);
      upd(12, 0, 10, 1, 0, 0, 0);     finish_move(0, 0);

      // randomized phase over a small page range
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         upd_valid      = ($urandom_range(0, 9) < 3);
         upd_page       = 20'($urandom_range(0, 3));
         upd_sub        = 2'($urandom_range(0, 3));
         upd_blk        = 4'($urandom_range(0, 15));
         upd_old_cls    = 2'($urandom_range(0, 3));
         upd_bytes      = 7'($urandom_range(0, 80));
         upd_sub_slack  = 13'($urandom_range(0, 70));
         upd_page_slack = 13'($urandom_range(0, 140));
         cfg_sub_thr    = 13'($urandom_range(10, 60));
         cfg_page_thr   = 13'($urandom_range(40, 160));
         mv_ready       = ($urandom_range(0, 1) == 1);
         mv_done        = ($urandom_range(0, 9) < 3);
         trap_ack       = ($urandom_range(0, 9) < 3);
         acc_valid      = ($urandom_range(0, 1) == 1);
         acc_page       = 20'($urandom_range(0, 3));
      end
      @(negedge clk);
      upd_valid = 0; mv_ready = 0; mv_done = 0; trap_ack = 0; acc_valid = 0;
      cyc(3);

      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

endmodule